// File: doc/BRIEF.md
# DS3 Alarm Indication Signal Detector

This block watches a DS3 bit stream that an upstream framer has already aligned. On each clock the framer presents one data bit and flags what kind of bit it is: a payload bit, a C-bit or an X-bit. It also marks the last cycle of each M-frame and reports whether it is currently in frame. The detector decides whether each whole M-frame carries the alarm indication pattern. A frame carries it when its payload alternates 1010…, every C-bit is 0 and every X-bit is 1.

The alternation phase is relearned at each M-frame. The first payload bit after a frame boundary sets the phase, and each later payload bit must be the inverse of the payload bit before it. Overhead bits that fall between payload bits are skipped. A run of qualifying frames raises the alarm output. A separate run of non-qualifying frames lowers it again. Frames seen while the framer is out of frame count as neither kind and leave both runs as they were.

Top module: `ds3_ais_detector`

## Requirements
- R1: After a synchronous reset, `ais_o`, `frame_ok_o` and `frame_bad_o` are all 0.
- R2: Within one M-frame, the first payload bit may be either 0 or 1. Every later payload bit must differ from the payload bit before it, and C-bit or X-bit cycles between them do not break the chain. A repeated payload value makes the frame non-qualifying.
- R3: A C-bit cycle (`cbit_stb`=1) whose `bit_i` is 1 makes the frame non-qualifying.
- R4: An X-bit cycle (`xbit_stb`=1) whose `bit_i` is 0 makes the frame non-qualifying.
- R5: The verdict for a frame appears one clock after the cycle with `mframe_end_i`=1, as a single-cycle pulse on either `frame_ok_o` or `frame_bad_o`, never both. The qualifiers presented on the end cycle itself belong to the frame that is ending.
- R6: `ais_o` rises on the verdict of the 63rd consecutive qualifying frame, and not earlier. It changes only one clock after an M-frame end.
- R7: A non-qualifying frame resets the run of qualifying frames to zero.
- R8: `ais_o` falls on the verdict of the 63rd consecutive non-qualifying frame. A qualifying frame resets that run to zero.
- R9: A frame during which `in_frame_i` was 0 in any cycle gives no verdict pulse and leaves both runs unchanged.
- R10: A frame that carries no payload bit at all is non-qualifying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Data bit for the current cycle |
| pay_stb_i | input | 1 | The current bit is a payload bit |
| cbit_stb_i | input | 1 | The current bit is a C-bit |
| xbit_stb_i | input | 1 | The current bit is an X-bit |
| mframe_end_i | input | 1 | Last cycle of the current M-frame |
| in_frame_i | input | 1 | Framer reports frame alignment |
| frame_ok_o | output | 1 | One-cycle pulse: the frame just ended qualifies |
| frame_bad_o | output | 1 | One-cycle pulse: the frame just ended does not qualify |
| ais_o | output | 1 | Alarm indication signal detected |

## Verification
All three outputs are registered on the same edge that samples `mframe_end_i`, so every result is due exactly one clock after the end cycle. The bench drives its inputs on falling edges. A behavioural model updates on the rising edge from those same inputs, and the outputs are compared with the model on the next falling edge, where the registered values are stable. Directed checks read the verdict and alarm at that same falling edge after each frame's end cycle. They target the 62nd and 63rd frames of each run and the frames that break a run.

// File: rtl/ais_pkg.sv
package ais_pkg;

  typedef struct packed {
    logic data;
    logic pay;
    logic cbit;
    logic xbit;
    logic mend;
    logic infr;
  } ais_slot_t;

  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_GOOD = 2'd1,
    VERD_BAD  = 2'd2
  } verdict_e;

endpackage

// File: rtl/ais_frame_judge.sv
module ais_frame_judge
  import ais_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ais_slot_t slot,
  output verdict_e  verdict
);

  logic seen_q, prev_q, fail_q, oof_q;
  logic seen_d, prev_d, fail_d, oof_d;

  always_comb begin
    seen_d = seen_q;
    prev_d = prev_q;
    fail_d = fail_q;
    oof_d  = oof_q;
    if (!slot.infr) oof_d = 1'b1;
    if (slot.pay) begin
      if (seen_q && (slot.data == prev_q)) fail_d = 1'b1;
      seen_d = 1'b1;
      prev_d = slot.data;
    end
    if (slot.cbit && slot.data)  fail_d = 1'b1;
    if (slot.xbit && !slot.data) fail_d = 1'b1;
    verdict = VERD_NONE;
    if (slot.mend) begin
      if (oof_d)                 verdict = VERD_NONE;
      else if (fail_d || !seen_d) verdict = VERD_BAD;
      else                        verdict = VERD_GOOD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || slot.mend) begin
      seen_q <= 1'b0;
      prev_q <= 1'b0;
      fail_q <= 1'b0;
      oof_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      prev_q <= prev_d;
      fail_q <= fail_d;
      oof_q  <= oof_d;
    end
  end

  AST_C_ONE_FAILS: assert property (@(posedge clk) disable iff (rst)
    (slot.cbit && slot.data && !slot.mend) |=> fail_q); // R3

  AST_X_ZERO_FAILS: assert property (@(posedge clk) disable iff (rst)
    (slot.xbit && !slot.data && !slot.mend) |=> fail_q); // R4

  AST_REPEAT_FAILS: assert property (@(posedge clk) disable iff (rst)
    (slot.pay && seen_q && (slot.data == prev_q) && !slot.mend) |=> fail_q); // R2

  AST_OOF_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (oof_q && slot.mend) |-> (verdict == VERD_NONE)); // R9

endmodule

// File: rtl/ais_run_counter.sv
module ais_run_counter #(
  parameter int LIMIT = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  output logic hit
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)               cnt <= '0;
    else if (inc && (cnt != TOP)) cnt <= cnt + 1'b1;
  end

  assign hit = inc && !clr && (cnt >= LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP); // R7

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R7

endmodule

// File: rtl/ds3_ais_detector.sv
module ds3_ais_detector
  import ais_pkg::*;
#(
  parameter int SET_FRAMES = 63,
  parameter int CLR_FRAMES = 63
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic pay_stb_i,
  input  logic cbit_stb_i,
  input  logic xbit_stb_i,
  input  logic mframe_end_i,
  input  logic in_frame_i,
  output logic frame_ok_o,
  output logic frame_bad_o,
  output logic ais_o
);

  ais_slot_t slot;
  verdict_e  verdict;
  logic      good, bad, set_hit, clr_hit;

  assign slot = '{data: bit_i, pay: pay_stb_i, cbit: cbit_stb_i,
                  xbit: xbit_stb_i, mend: mframe_end_i, infr: in_frame_i};

  ais_frame_judge u_judge (
    .clk     (clk),
    .rst     (rst),
    .slot    (slot),
    .verdict (verdict)
  );

  assign good = (verdict == VERD_GOOD);
  assign bad  = (verdict == VERD_BAD);

  ais_run_counter #(.LIMIT(SET_FRAMES)) u_good_run (
    .clk (clk), .rst (rst), .inc (good), .clr (bad), .hit (set_hit)
  );

  ais_run_counter #(.LIMIT(CLR_FRAMES)) u_bad_run (
    .clk (clk), .rst (rst), .inc (bad), .clr (good), .hit (clr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_ok_o  <= 1'b0;
      frame_bad_o <= 1'b0;
      ais_o       <= 1'b0;
    end else begin
      frame_ok_o  <= good;
      frame_bad_o <= bad;
      if (set_hit)      ais_o <= 1'b1;
      else if (clr_hit) ais_o <= 1'b0;
    end
  end

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok_o && frame_bad_o)); // R5

  AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (frame_ok_o || frame_bad_o) |-> $past(mframe_end_i)); // R5

  AST_AIS_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(ais_o) |-> frame_ok_o); // R6

  AST_AIS_FALL_ON_BAD: assert property (@(posedge clk) disable iff (rst)
    $fell(ais_o) |-> frame_bad_o); // R8

  AST_AIS_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$past(mframe_end_i) |-> $stable(ais_o)); // R6

endmodule

// File: tb/sim_ds3_ais_detector.sv
module sim_ds3_ais_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_i = 1'b0, pay = 1'b0, cst = 1'b0, xst = 1'b0, mend = 1'b0, infr = 1'b1;
  logic frame_ok, frame_bad, ais;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // behavioural reference model
  int m_good = 0, m_bad = 0;
  bit m_seen, m_prev, m_fail, m_oof;
  bit e_ok, e_bad, e_ais;
  bit last_ok, last_bad;

  always #2 clk = ~clk;

  ds3_ais_detector u0 (
    .clk (clk), .rst (rst), .bit_i (bit_i), .pay_stb_i (pay),
    .cbit_stb_i (cst), .xbit_stb_i (xst), .mframe_end_i (mend),
    .in_frame_i (infr), .frame_ok_o (frame_ok), .frame_bad_o (frame_bad),
    .ais_o (ais)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_good = 0; m_bad = 0; m_seen = 0; m_prev = 0; m_fail = 0; m_oof = 0;
      e_ok = 0; e_bad = 0; e_ais = 0;
    end else begin
      e_ok = 0; e_bad = 0;
      if (!infr) m_oof = 1;
      if (pay) begin
        if (m_seen && bit_i == m_prev) m_fail = 1;
        m_seen = 1; m_prev = bit_i;
      end
      if (cst && bit_i) m_fail = 1;
      if (xst && !bit_i) m_fail = 1;
      if (mend) begin
        if (!m_oof) begin
          if (m_fail || !m_seen) begin
            e_bad = 1; m_good = 0; m_bad++;
            if (m_bad >= 63) e_ais = 0;
          end else begin
            e_ok = 1; m_bad = 0; m_good++;
            if (m_good >= 63) e_ais = 1;
          end
        end
        m_seen = 0; m_prev = 0; m_fail = 0; m_oof = 0;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R5 frame_ok", frame_ok, e_ok);
      check("R5 frame_bad", frame_bad, e_bad);
      check("R6 R8 ais", ais, e_ais);
    end
  end

  // kind: 0 good, 1 repeat payload, 2 C-bit one, 3 X-bit zero, 4 out of frame, 5 no payload
  task automatic send_frame(input int kind, input bit phase);
    int p = 0;
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      pay = 0; cst = 0; xst = 0; infr = 1;
      if (s == 3 || s == 7) begin
        cst = 1; bit_i = (kind == 2 && s == 7);
      end else if (s == 10) begin
        xst = 1; bit_i = (kind != 3);
      end else begin
        pay = (kind != 5);
        bit_i = phase ^ p[0];
        if (kind == 1 && p == 5) bit_i = ~bit_i;
        p++;
      end
      if (kind == 4 && s == 5) infr = 0;
    end
    @(negedge clk);
    pay = 0; cst = 0; xst = 0; infr = 1; mend = 1; bit_i = 0;
    @(negedge clk);
    mend = 0;
    last_ok = frame_ok; last_bad = frame_bad;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ais reset", ais, 1'b0);
    check("R1 ok reset", frame_ok, 1'b0);
    check("R1 bad reset", frame_bad, 1'b0);
    rst = 0;

    send_frame(0, 0);
    check("R2 phase0 ok", last_ok, 1'b1);
    send_frame(0, 1);
    check("R2 phase1 ok", last_ok, 1'b1);
    for (int i = 0; i < 60; i++) send_frame(0, i[0]);
    check("R6 no ais at 62", ais, 1'b0);
    send_frame(2, 0);
    check("R3 C-bit one bad", last_bad, 1'b1);
    check("R7 run reset keeps ais low", ais, 1'b0);

    for (int i = 0; i < 62; i++) send_frame(0, i[1]);
    check("R7 no ais at 62 after reset", ais, 1'b0);
    send_frame(4, 0);
    check("R9 oof no ok", last_ok, 1'b0);
    check("R9 oof no bad", last_bad, 1'b0);
    send_frame(0, 1);
    check("R6 ais at 63", ais, 1'b1);
    check("R9 run held across oof", last_ok, 1'b1);

    send_frame(1, 0);
    check("R2 repeated payload bad", last_bad, 1'b1);
    send_frame(3, 1);
    check("R4 X-bit zero bad", last_bad, 1'b1);
    send_frame(5, 0);
    check("R10 no payload bad", last_bad, 1'b1);
    for (int i = 0; i < 59; i++) send_frame(1 + (i % 3), i[0]);
    check("R8 ais kept at 62 bad", ais, 1'b1);
    send_frame(0, 0);
    check("R8 good breaks bad run", ais, 1'b1);
    for (int i = 0; i < 62; i++) send_frame(5 - (i % 4 == 0 ? 4 : 0), 1);
    check("R8 ais kept at 62 after reset", ais, 1'b1);
    send_frame(3, 0);
    check("R8 ais cleared at 63", ais, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule